// File: doc/BRIEF.md
# Five-Leg Common-Mode-Cancelling PWM Encoder

This block drives the upper and lower switch gates of five inverter legs built on coupled inductors, with the switching pattern chosen so that the five phase voltages add up to zero at every instant. It uses one shared triangular carrier. Each leg compares its own signed reference against that carrier. The leg's three-level target is then its own comparison bit minus the bit of a partner leg. The partner is either the next leg (stride one) or the leg two positions ahead (stride two), set by a mode input. The differences run around the ring of legs, so their sum cancels in both modes.

A target of +1 or -1 drives exactly one gate of the pair. For a target of zero the coupled inductor offers two states: both gates on, which energizes the core, and both gates off, which de-energizes it. A per-leg sequencer picks between them so that each core sees equal energizing and de-energizing time in every carrier period. The zero state used at the end of a period is also the one used at the start of the next period, so no leg flips both gates at a period edge. References and the mode bit are captured once per period, at the carrier valley, so the pattern inside a period is symmetric about the carrier peak.

Top module: `cmc5_pwm_enc`

## Requirements
- R1: While reset is low, every upper and lower gate output is 0.
- R2: The carrier step s counts 0 to 2^(W+1)-1 and wraps, with W = REF_W. The carrier value is s in the first half and 2^(W+1)-1-s in the second half. The comparison bit of a leg is 1 when its two's-complement reference plus 2^(W-1) is greater than or equal to the carrier value.
- R3: The target of leg i is its own comparison bit minus the bit of leg (i+1) mod 5 when mode is 0, and minus the bit of leg (i+2) mod 5 when mode is 1. Leg i uses ref_i bits [i*REF_W +: REF_W], and leg 0 is the least significant field.
- R4: In every cycle the five targets sum to zero, so the sum over the legs of (upper gate minus lower gate) is zero.
- R5: A target of +1 gives upper=1 and lower=0. A target of -1 gives upper=0 and lower=1.
- R6: A target of 0 gives upper equal to lower. Both gates are on when (s is in the second half) XOR (the count of completed carrier periods since reset is odd), and both are off otherwise.
- R7: At the first step of each period, every leg's gates equal those of the last step of the previous period.
- R8: Over each carrier period, each leg spends as many cycles with both gates on as with both gates off.
- R9: References and the mode bit are sampled only at step 0. Changes at any other step have no effect on the outputs until the next step 0.
- R10: The gates are registered. The outputs after a clock edge reflect the step and sampled inputs in effect in the cycle before that edge.
- R11: No leg goes directly from (upper=1, lower=0) to (upper=0, lower=1) or back in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Partner select: 0 for the next leg, 1 for the leg two ahead |
| ref_i | input | NPH*REF_W | Five signed references, leg 0 in the low field |
| gate_hi_o | output | NPH | Upper switch gate per leg |
| gate_lo_o | output | NPH | Lower switch gate per leg |

## Verification
The assertions expect references and mode to be arbitrary. The only thing the block can rely on is that it latches them itself at the valley, which is why the balance and mode-hold properties do not depend on the stimulus holding its inputs steady. The bench deliberately changes references and mode in the middle of some periods to exercise that capture. It sweeps a range of reference sets in both partner modes and also drives the extreme values, where a leg's comparison bit stays high for the whole period or is high only at the valley.

// File: rtl/cmc5_pwm_pkg.sv
package cmc5_pwm_pkg;

    // Ternary leg target
    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b10
    } lvl_t;

    // Registered state of one leg
    typedef struct packed {
        logic bnd;   // zero state used in the first half of the period
        logic hi;
        logic lo;
    } leg_st_t;

    // Partner leg index for a given ring stride
    function automatic int partner_of(input int idx, input int stride, input int n);
        return (idx + stride) % n;
    endfunction

endpackage

// File: rtl/cmc5_carrier.sv
module cmc5_carrier #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W:0]   step_o,
    output logic [CNT_W-1:0] carrier_o,
    output logic             half_o,
    output logic             valley_o
);
    typedef struct packed {
        logic [CNT_W:0] idx;
    } car_st_t;

    car_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.idx = st_q.idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Rising half repeats the peak once, falling half repeats the valley once
    assign step_o    = st_q.idx;
    assign half_o    = st_q.idx[CNT_W];
    assign carrier_o = st_q.idx[CNT_W] ? ~st_q.idx[CNT_W-1:0] : st_q.idx[CNT_W-1:0];
    assign valley_o  = (st_q.idx == '0);
endmodule

// File: rtl/cmc5_sampler.sv
module cmc5_sampler #(
    parameter int NPH   = 5,
    parameter int REF_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valley_i,
    input  logic                   mode_i,
    input  logic [NPH*REF_W-1:0]   ref_i,
    output logic                   far_o,
    output logic [NPH*REF_W-1:0]   ref_o
);
    typedef struct packed {
        logic                 far;
        logic [NPH*REF_W-1:0] refs;
    } smp_t;

    smp_t st_q, st_d, use_w;

    always_comb begin
        use_w = st_q;
        if (valley_i) begin
            use_w.far  = mode_i;
            use_w.refs = ref_i;
        end
        st_d = use_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign far_o = use_w.far;
    assign ref_o = use_w.refs;
endmodule

// File: rtl/cmc5_leg.sv
module cmc5_leg
    import cmc5_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_own_i,
    input  logic bit_near_i,
    input  logic bit_far_i,
    input  logic far_sel_i,
    input  logic half_i,
    input  logic valley_i,
    output lvl_t lvl_o,
    output logic gate_hi_o,
    output logic gate_lo_o
);
    leg_st_t st_q, st_d;
    logic    bit_par;
    logic    bnd_use;
    logic    zero_on;

    always_comb begin
        bit_par = far_sel_i ? bit_far_i : bit_near_i;
        if (bit_own_i && !bit_par)      lvl_o = LVL_POS;
        else if (!bit_own_i && bit_par) lvl_o = LVL_NEG;
        else                            lvl_o = LVL_ZERO;

        // Boundary state flips at every valley; the second half uses its opposite
        bnd_use = valley_i ? ~st_q.bnd : st_q.bnd;
        zero_on = half_i ^ bnd_use;

        st_d     = st_q;
        st_d.bnd = bnd_use;
        unique case (lvl_o)
            LVL_POS: begin st_d.hi = 1'b1;    st_d.lo = 1'b0;    end
            LVL_NEG: begin st_d.hi = 1'b0;    st_d.lo = 1'b1;    end
            default: begin st_d.hi = zero_on; st_d.lo = zero_on; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{bnd: 1'b1, hi: 1'b0, lo: 1'b0};
        else        st_q <= st_d;
    end

    assign gate_hi_o = st_q.hi;
    assign gate_lo_o = st_q.lo;
endmodule

// File: rtl/cmc5_pwm_enc.sv
module cmc5_pwm_enc
    import cmc5_pwm_pkg::*;
#(
    parameter int NPH   = 5,
    parameter int REF_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic [NPH*REF_W-1:0] ref_i,
    output logic [NPH-1:0]       gate_hi_o,
    output logic [NPH-1:0]       gate_lo_o
);
    logic [REF_W:0]       step_w;
    logic [REF_W-1:0]     carrier_w;
    logic                 half_w;
    logic                 valley_w;
    logic                 far_use_w;
    logic [NPH*REF_W-1:0] ref_use_w;
    logic [NPH-1:0]       cmp_w;
    logic [NPH-1:0]       tgt_pos_w;
    logic [NPH-1:0]       tgt_neg_w;

    cmc5_carrier #(.CNT_W(REF_W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_o   (step_w),
        .carrier_o(carrier_w),
        .half_o   (half_w),
        .valley_o (valley_w)
    );

    cmc5_sampler #(.NPH(NPH), .REF_W(REF_W)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .valley_i(valley_w),
        .mode_i  (mode_i),
        .ref_i   (ref_i),
        .far_o   (far_use_w),
        .ref_o   (ref_use_w)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_cmp
        logic [REF_W-1:0] r_w;
        logic [REF_W-1:0] biased_w;
        assign r_w      = ref_use_w[i*REF_W +: REF_W];
        assign biased_w = {~r_w[REF_W-1], r_w[REF_W-2:0]};
        assign cmp_w[i] = (biased_w >= carrier_w);
    end

    for (genvar i = 0; i < NPH; i++) begin : g_leg
        localparam int NEAR = partner_of(i, 1, NPH);
        localparam int FAR  = partner_of(i, 2, NPH);
        lvl_t lvl_w;

        cmc5_leg u_leg (
            .clk       (clk),
            .rst_n     (rst_n),
            .bit_own_i (cmp_w[i]),
            .bit_near_i(cmp_w[NEAR]),
            .bit_far_i (cmp_w[FAR]),
            .far_sel_i (far_use_w),
            .half_i    (half_w),
            .valley_i  (valley_w),
            .lvl_o     (lvl_w),
            .gate_hi_o (gate_hi_o[i]),
            .gate_lo_o (gate_lo_o[i])
        );

        assign tgt_pos_w[i] = (lvl_w == LVL_POS);
        assign tgt_neg_w[i] = (lvl_w == LVL_NEG);
    end
endmodule

// File: rtl/cmc5_pwm_enc_chk.sv
module cmc5_pwm_enc_chk #(
    parameter int NPH   = 5,
    parameter int REF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REF_W:0]   step,
    input logic             far_use,
    input logic [NPH-1:0]   tgt_pos,
    input logic [NPH-1:0]   tgt_neg,
    input logic [NPH-1:0]   gate_hi,
    input logic [NPH-1:0]   gate_lo
);
    localparam int DW = REF_W + 3;

    logic                 armed_q;
    logic signed [DW-1:0] diff_q [NPH];

    // Running (both-on minus both-off) count per leg over one output period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            for (int i = 0; i < NPH; i++) diff_q[i] <= '0;
        end else begin
            if (step == 1) armed_q <= 1'b1;
            for (int i = 0; i < NPH; i++) begin
                logic signed [DW-1:0] c;
                c = (gate_hi[i] && gate_lo[i])   ?  DW'(1) :
                    (!gate_hi[i] && !gate_lo[i]) ? -DW'(1) : '0;
                diff_q[i] <= (step == 1) ? c : diff_q[i] + c;
            end
        end
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (!rst_n |-> (gate_hi == '0 && gate_lo == '0)));

    assert_sum_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tgt_pos) == $countones(tgt_neg));

    assert_active_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hi & ~gate_lo) == $past(tgt_pos)) && ((gate_lo & ~gate_hi) == $past(tgt_neg)));

    assert_zero_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi ~^ gate_lo) == $past(~(tgt_pos | tgt_neg)));

    assert_boundary_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 1) |-> (gate_hi == $past(gate_hi) && gate_lo == $past(gate_lo)));

    for (genvar i = 0; i < NPH; i++) begin : g_bal
        assert_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && step == 1) |-> (diff_q[i] == '0));
    end

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step != 0) |-> $stable(far_use));

    assert_no_reverse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hi & ~gate_lo & $past(gate_lo & ~gate_hi)) |
         (gate_lo & ~gate_hi & $past(gate_hi & ~gate_lo))) == '0);
endmodule

bind cmc5_pwm_enc cmc5_pwm_enc_chk #(.NPH(NPH), .REF_W(REF_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step_w),
    .far_use(far_use_w),
    .tgt_pos(tgt_pos_w),
    .tgt_neg(tgt_neg_w),
    .gate_hi(gate_hi_o),
    .gate_lo(gate_lo_o)
);

// File: tb/cmc5_pwm_enc_tb.sv
module cmc5_pwm_enc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPH  = 5;
    localparam int RW   = 4;
    localparam int PER  = 2 ** (RW + 1);
    localparam int HALF = 2 ** RW;
    localparam int BIAS = 2 ** (RW - 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_i = 1'b0;
    logic [NPH*RW-1:0] ref_i = '0;
    logic [NPH-1:0]    gate_hi_o, gate_lo_o;

    int n_tests = 0;
    int n_fail  = 0;
    int edge_n  = 0;
    int cur_ref [NPH];
    int lat_ref [NPH];
    int cur_mode = 0;
    int lat_mode = 0;
    int on_cnt  [NPH];
    int off_cnt [NPH];
    bit glitched = 0;
    logic [NPH-1:0] prev_hi, prev_lo;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmc5_pwm_enc #(.NPH(NPH), .REF_W(RW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_i),
        .ref_i    (ref_i),
        .gate_hi_o(gate_hi_o),
        .gate_lo_o(gate_lo_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_n);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic drive();
        for (int j = 0; j < NPH; j++) ref_i[j*RW +: RW] = RW'(cur_ref[j]);
        mode_i = cur_mode[0];
    endtask

    function automatic int cmp_bit(input int j, input int c);
        return ((lat_ref[j] + BIAS) >= c) ? 1 : 0;
    endfunction

    // One clock: inputs already driven; predicts and checks the outputs after the edge
    task automatic step();
        int s, p, c, half, zon, tgt, par, sum;
        logic [NPH-1:0] eh, el;
        s = edge_n % PER;
        p = edge_n / PER;
        if (s == 0) begin
            for (int j = 0; j < NPH; j++) lat_ref[j] = cur_ref[j];
            lat_mode = cur_mode;
            glitched = 0;
        end
        c    = (s < HALF) ? s : (PER - 1 - s);
        half = (s >= HALF) ? 1 : 0;
        zon  = half ^ (p % 2);
        for (int i = 0; i < NPH; i++) begin
            par = (i + (lat_mode ? 2 : 1)) % NPH;
            tgt = cmp_bit(i, c) - cmp_bit(par, c);
            eh[i] = (tgt > 0) ? 1'b1 : (tgt < 0) ? 1'b0 : zon[0];
            el[i] = (tgt < 0) ? 1'b1 : (tgt > 0) ? 1'b0 : zon[0];
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NPH; i++) begin
            if (glitched) begin
                chk("R9 R10 upper", int'(gate_hi_o[i]), int'(eh[i]));
                chk("R9 R10 lower", int'(gate_lo_o[i]), int'(el[i]));
            end else if (eh[i] != el[i]) begin
                chk("R2 R3 R5 upper", int'(gate_hi_o[i]), int'(eh[i]));
                chk("R2 R3 R5 lower", int'(gate_lo_o[i]), int'(el[i]));
            end else begin
                chk("R6 upper", int'(gate_hi_o[i]), int'(eh[i]));
                chk("R6 lower", int'(gate_lo_o[i]), int'(el[i]));
            end
            if (gate_hi_o[i] && gate_lo_o[i])   on_cnt[i]++;
            if (!gate_hi_o[i] && !gate_lo_o[i]) off_cnt[i]++;
            if (edge_n > 0)
                chk("R11 reverse swap", int'((gate_hi_o[i] ^ prev_hi[i]) && (gate_lo_o[i] ^ prev_lo[i])
                                            && (gate_hi_o[i] != gate_lo_o[i])), 0);
        end
        sum = 0;
        for (int i = 0; i < NPH; i++) sum += int'(gate_hi_o[i]) - int'(gate_lo_o[i]);
        chk("R4 phase sum", sum, 0);
        if (s == 0 && edge_n > 0) begin
            chk("R7 boundary upper", int'(gate_hi_o), int'(prev_hi));
            chk("R7 boundary lower", int'(gate_lo_o), int'(prev_lo));
        end
        if (s == PER - 1) begin
            for (int i = 0; i < NPH; i++) begin
                chk("R8 on-off balance", on_cnt[i], off_cnt[i]);
                on_cnt[i] = 0;
                off_cnt[i] = 0;
            end
        end
        prev_hi = gate_hi_o;
        prev_lo = gate_lo_o;
        edge_n++;
    endtask

    // Runs one carrier period; optionally disturbs the inputs mid-period
    task automatic run_period(input bit disturb);
        for (int k = 0; k < PER; k++) begin
            if (disturb && k == 12) begin
                for (int j = 0; j < NPH; j++) cur_ref[j] = ((cur_ref[j] + 8 + 5) % 16) - 8;
                cur_mode = 1 - cur_mode;
                drive();
                glitched = 1;
            end
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < NPH; i++) begin
            cur_ref[i] = i - 2;
            on_cnt[i]  = 0;
            off_cnt[i] = 0;
        end
        drive();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R1 reset upper", int'(gate_hi_o), 0);
            chk("R1 reset lower", int'(gate_lo_o), 0);
        end
        rst_n = 1'b1;

        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int j = 0; j < NPH; j++) cur_ref[j] = ((a * (j + 1) + 3 * j) % 16) - 8;
                cur_mode = m;
                drive();
                run_period(a[0]);
            end
        end

        // Extreme references in both modes
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 3; e++) begin
                for (int j = 0; j < NPH; j++)
                    cur_ref[j] = (e == 0) ? -8 : (e == 1) ? 7 : ((j % 2) ? 7 : -8);
                cur_mode = m;
                drive();
                run_period(1'b0);
            end
        end

        summary();
    end
endmodule